// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This block resolves the operand address for the indexed memory mode of a small 16-bit processor. An instruction carries an operand byte whose upper nibble selects a register and whose lower nibble is a modifier. The modifier can adjust the register before or after use, add a signed displacement byte that follows in the instruction stream, and take the result as a pointer to a 16-bit word in memory that holds the final address.

The caller pulses `start` with the operand byte, the displacement byte and the operand size. The unit reads the selected register through a combinational read port. For indirect forms it fetches the pointer word over a byte-wide memory read handshake. It then pulses `done` with the final address, the instruction length and, when the modifier asks for it, a one-cycle register write carrying the adjusted register value.

Top module: `idx_ea_unit`

## Requirements
- R1: Operand byte bits [7:4] select the register and bits [3:0] are the modifier. Modifier bits [1:0] = 0 (plain) give an address equal to the register value and cause no register write.
- R2: Modifier bits [1:0] = 1 (post-increment) address with the unmodified register value and write back register + step.
- R3: Modifier bits [1:0] = 2 (pre-decrement) address with register − step and write back register − step, wrapping modulo 2^16.
- R4: The step is 1 when `word_op` = 0 and 2 when `word_op` = 1.
- R5: Modifier bit 3 adds the displacement byte, sign-extended to 16 bits, to the (pre-adjusted) register value. `instr_len` is 3 with bit 3 set and 2 without it.
- R6: The written-back register value never includes the displacement.
- R7: Modifier bit 2 makes the computed value a pointer. The unit reads the byte at the pointer (the high half) and then the byte at pointer + 1 (the low half), exactly two memory reads. The final address is {high, low}.
- R8: Modifiers with bits [1:0] = 3 (3, 7, B, F) raise `illegal` together with `done` on the cycle after `start`. They make no register write and no memory read.
- R9: `done` is a one-cycle pulse. Without indirection it rises on the cycle after `start`. With indirection it rises on the cycle after the second accepted read. `rf_wr_en` is high only together with `done`.
- R10: `start` is ignored while `busy` is high. The operation in flight completes unchanged and no extra result appears.
- R11: After reset, `busy`, `done`, `illegal`, `mem_rd_req` and `rf_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (sampled when idle) |
| spec | input | 8 | Operand byte: register index [7:4], modifier [3:0] |
| disp | input | 8 | Displacement byte, signed |
| word_op | input | 1 | 1 = word operand (step 2), 0 = byte operand (step 1) |
| rf_rd_idx | output | 4 | Register read index |
| rf_rd_data | input | 16 | Register read data, combinational |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 16 | Adjusted register value |
| mem_rd_req | output | 1 | Memory read request, held until accepted |
| mem_rd_addr | output | 16 | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid; completes the request |
| mem_rd_data | input | 8 | Read data byte |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Reserved modifier, valid with done |
| ea | output | 16 | Final effective address, valid with done |
| instr_len | output | 2 | Instruction length in bytes, valid with done |

## Verification
A wrong pointer register in the fetch sequence shows up as a wrong byte half in `ea` at the very next `done`, because each half comes from a distinct memory location. A stuck sequencer state appears as a missing `done` within a few cycles of the last accepted read. A stale pending write appears as `rf_wr_en` on a later illegal or plain operation, and an adjustment-order error appears as an `ea` or `rf_wr_data` off by one step or by the displacement on the same `done`. Random mixes of all sixteen modifiers, with registers evolving across operations and variable memory latency, are combined with directed wraparound, negative-displacement and busy-start cases.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    // register adjustment selected by modifier bits [1:0]
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_POST = 2'd1,
        ADJ_PRE  = 2'd2,
        ADJ_BAD  = 2'd3
    } adj_e;

    typedef struct packed {
        logic       use_disp;
        logic       indirect;
        adj_e       adj;
        logic       bad;
        logic [1:0] len;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } st_e;

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [3:0] modifier,
    output mode_t      mode
);

    always_comb begin
        mode.use_disp = modifier[3];
        mode.indirect = modifier[2];
        mode.adj      = adj_e'(modifier[1:0]);
        mode.bad      = (modifier[1:0] == 2'b11);
        mode.len      = modifier[3] ? 2'd3 : 2'd2;
    end

    // a reserved form never carries a legal adjustment
    always_comb begin
        if (mode.bad) begin
            assert_bad_adj_R8: assert (mode.adj == ADJ_BAD);
        end
    end

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              word_op,
    input  mode_t             mode,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] new_val,
    output logic              wr_req
);

    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] inc_val;
    logic [ADDR_W-1:0] dec_val;
    logic [ADDR_W-1:0] base;

    generate
        if (DISP_W < ADDR_W) begin : g_sext
            assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        step    = word_op ? STEP_WORD : STEP_BYTE;
        inc_val = reg_val + step;
        dec_val = reg_val - step;
        base    = (mode.adj == ADJ_PRE) ? dec_val : reg_val;
        ptr     = base + (mode.use_disp ? disp_ext : '0);
        case (mode.adj)
            ADJ_POST: begin new_val = inc_val; wr_req = 1'b1; end
            ADJ_PRE:  begin new_val = dec_val; wr_req = 1'b1; end
            default:  begin new_val = reg_val; wr_req = 1'b0; end
        endcase
    end

    // write-back is one step from the register, never displaced
    always_comb begin
        if (wr_req) begin
            assert_upd_one_step_R6: assert ((new_val == inc_val) || (new_val == dec_val));
        end
    end

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_W  = 8,
    parameter int RIDX_W = 4,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RIDX_W+3:0] spec,
    input  logic [DISP_W-1:0] disp,
    input  logic              word_op,
    output logic [RIDX_W-1:0] rf_rd_idx,
    input  logic [ADDR_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [ADDR_W-1:0] rf_wr_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [MEM_W-1:0]  mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [ADDR_W-1:0] ea,
    output logic [1:0]        instr_len
);

    localparam int MOD_W  = 4;
    localparam int SPEC_W = RIDX_W + MOD_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] ptr;
        logic [MEM_W-1:0]  hi;
        logic [ADDR_W-1:0] ea;
        logic              done;
        logic              bad;
        logic [1:0]        len;
        logic              wr_pend;
        logic [RIDX_W-1:0] widx;
        logic [ADDR_W-1:0] wval;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    mode_t             mode;
    logic [ADDR_W-1:0] calc_ptr;
    logic [ADDR_W-1:0] calc_new;
    logic              calc_wr;
    logic [RIDX_W-1:0] sel_idx;

    assign sel_idx   = spec[SPEC_W-1 -: RIDX_W];
    assign rf_rd_idx = sel_idx;

    idx_ea_decode u_decode (
        .modifier (spec[MOD_W-1:0]),
        .mode     (mode)
    );

    idx_ea_calc #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_calc (
        .reg_val (rf_rd_data),
        .disp    (disp),
        .word_op (word_op),
        .mode    (mode),
        .ptr     (calc_ptr),
        .new_val (calc_new),
        .wr_req  (calc_wr)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.bad  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.len  = mode.len;
                    ctl_d.widx = sel_idx;
                    ctl_d.wval = calc_new;
                    if (mode.bad) begin
                        ctl_d.done    = 1'b1;
                        ctl_d.bad     = 1'b1;
                        ctl_d.wr_pend = 1'b0;
                        ctl_d.ea      = '0;
                    end else if (mode.indirect) begin
                        ctl_d.wr_pend = calc_wr;
                        ctl_d.ptr     = calc_ptr;
                        ctl_d.st      = ST_HI;
                    end else begin
                        ctl_d.wr_pend = calc_wr;
                        ctl_d.ea      = calc_ptr;
                        ctl_d.done    = 1'b1;
                    end
                end
            end
            ST_HI: begin
                if (mem_rd_valid) begin
                    ctl_d.hi  = mem_rd_data;
                    ctl_d.ptr = ctl_q.ptr + ADDR_ONE;
                    ctl_d.st  = ST_LO;
                end
            end
            ST_LO: begin
                if (mem_rd_valid) begin
                    ctl_d.ea   = ADDR_W'({ctl_q.hi, mem_rd_data});
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign mem_rd_req  = (ctl_q.st == ST_HI) || (ctl_q.st == ST_LO);
    assign mem_rd_addr = ctl_q.ptr;
    assign done        = ctl_q.done;
    assign illegal     = ctl_q.bad;
    assign ea          = ctl_q.ea;
    assign instr_len   = ctl_q.len;
    assign rf_wr_en    = ctl_q.done & ctl_q.wr_pend;
    assign rf_wr_idx   = ctl_q.widx;
    assign rf_wr_data  = ctl_q.wval;

    assert_wr_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done)
        else $error("register write outside done");

    assert_direct_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !spec[2]) |=> done)
        else $error("direct form did not finish next cycle");

    assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (spec[1:0] == 2'b11)) |=> (illegal && done && !rf_wr_en && !mem_rd_req))
        else $error("reserved modifier misbehaved");

    assert_lo_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HI && mem_rd_valid) |=> (mem_rd_req && (mem_rd_addr == $past(mem_rd_addr) + ADDR_ONE)))
        else $error("second read not at next byte");

    assert_lo_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LO && mem_rd_valid) |=> (done && !busy))
        else $error("no done after second read");

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_rd_valid) |=> (busy && $stable(mem_rd_addr) && !done))
        else $error("start disturbed a busy unit");

endmodule

// File: tb/idx_ea_unit_bench.sv
`timescale 1ns/1ps
module idx_ea_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  spec = 8'h00;
    logic [7:0]  disp = 8'h00;
    logic        word_op = 1'b0;
    logic [3:0]  rf_rd_idx;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [3:0]  rf_wr_idx;
    logic [15:0] rf_wr_data;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [7:0]  mem_rd_data;
    logic        busy, done, illegal;
    logic [15:0] ea;
    logic [1:0]  instr_len;

    logic [15:0] regs [16];
    int          checks = 0;
    int          fails = 0;
    int          grants = 0;
    int          req_seen = 0;
    int          force_wait = -1;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    idx_ea_unit u_idx_ea_unit (
        .clk (clk), .rst_n (rst_n), .start (start), .spec (spec), .disp (disp),
        .word_op (word_op), .rf_rd_idx (rf_rd_idx), .rf_rd_data (rf_rd_data),
        .rf_wr_en (rf_wr_en), .rf_wr_idx (rf_wr_idx), .rf_wr_data (rf_wr_data),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .busy (busy), .done (done), .illegal (illegal), .ea (ea),
        .instr_len (instr_len)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd13;
        return m ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: random latency 0..2 cycles per byte
    initial begin
        int wcnt;
        wcnt = 0;
        mem_rd_valid = 1'b0;
        mem_rd_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                if (wcnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mbyte(mem_rd_addr);
                    grants++;
                    wcnt = (force_wait >= 0) ? force_wait : int'($urandom % 3);
                end else begin
                    mem_rd_valid = 1'b0;
                    wcnt--;
                end
                req_seen++;
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic run_op(input logic [7:0] sp, input logic [7:0] dp,
                          input bit wd, input bit poke);
        logic [15:0] r, st, base, ptr, exp_ea, nv;
        logic [3:0]  m;
        bit          bad, wr_e;
        string       tag;
        int          cnt;
        r    = regs[sp[7:4]];
        m    = sp[3:0];
        st   = wd ? 16'd2 : 16'd1;
        bad  = (m[1:0] == 2'b11);
        base = (m[1:0] == 2'b10) ? r - st : r;
        ptr  = base + (m[3] ? {{8{dp[7]}}, dp} : 16'h0000);
        exp_ea = m[2] ? {mbyte(ptr), mbyte(ptr + 16'd1)} : ptr;
        wr_e = !bad && (m[1:0] == 2'b01 || m[1:0] == 2'b10);
        nv   = (m[1:0] == 2'b01) ? r + st : r - st;
        if (bad)                     tag = "R8";
        else if (m[2])               tag = "R7";
        else if (m[3])               tag = "R5";
        else if (m[1:0] == 2'b01)    tag = "R2";
        else if (m[1:0] == 2'b10)    tag = "R3";
        else                         tag = "R1";

        @(negedge clk);
        spec = sp; disp = dp; word_op = wd; start = 1'b1;
        grants = 0; req_seen = 0;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            spec = 8'h20; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 64) begin
            @(negedge clk);
            cnt++;
        end
        chk("R9", "done seen", 32'(done), 32'd1);
        if (!m[2] || bad) chk("R9", "direct latency", 32'(cnt), 32'd0);
        chk(bad ? "R8" : "R1", "illegal flag", 32'(illegal), 32'(bad));
        chk("R5", "instr_len", 32'(instr_len), m[3] ? 32'd3 : 32'd2);
        if (!bad) chk(tag, "ea", 32'(ea), 32'(exp_ea));
        chk(m[3] ? "R6" : tag, "wr_en", 32'(rf_wr_en), 32'(wr_e));
        if (wr_e) begin
            chk("R4", "wr_idx", 32'(rf_wr_idx), 32'(sp[7:4]));
            chk(m[3] ? "R6" : "R4", "wr_data", 32'(rf_wr_data), 32'(nv));
            regs[sp[7:4]] = nv;
        end
        if (bad) chk("R8", "memory reads", 32'(req_seen), 32'd0);
        else if (m[2]) chk("R7", "memory reads", 32'(grants), 32'd2);
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk("R10", "no extra done", 32'(done), 32'd0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h1111 + 16'h0102);
        regs[4] = 16'h4000;
        regs[6] = 16'h0000;
        regs[8] = 16'hFFFF;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", 32'(busy), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "illegal", 32'(illegal), 32'd0);
        chk("R11", "mem_rd_req", 32'(mem_rd_req), 32'd0);
        chk("R11", "rf_wr_en", 32'(rf_wr_en), 32'd0);

        run_op(8'h40, 8'h00, 1'b1, 1'b0);  // R1 plain
        run_op(8'h41, 8'h00, 1'b0, 1'b0);  // R2 post-inc, R4 byte step
        run_op(8'h41, 8'h00, 1'b1, 1'b0);  // R2 post-inc, R4 word step
        run_op(8'h62, 8'h00, 1'b1, 1'b0);  // R3 pre-dec wraps 0 -> FFFE
        run_op(8'h81, 8'h00, 1'b1, 1'b0);  // R2 wrap FFFF -> 0001
        run_op(8'h48, 8'h7F, 1'b0, 1'b0);  // R5 positive disp
        run_op(8'h48, 8'h80, 1'b0, 1'b0);  // R5 negative disp
        run_op(8'h29, 8'hF0, 1'b1, 1'b0);  // R6 post-inc with disp
        run_op(8'h2A, 8'h10, 1'b0, 1'b0);  // R6 pre-dec with disp
        run_op(8'h34, 8'h00, 1'b0, 1'b0);  // R7 indirect plain
        run_op(8'h3C, 8'hFE, 1'b1, 1'b0);  // R7 indirect with disp
        run_op(8'h5D, 8'h05, 1'b1, 1'b0);  // R7 indirect post-inc
        run_op(8'h5E, 8'h81, 1'b0, 1'b0);  // R7 indirect pre-dec
        run_op(8'h13, 8'h00, 1'b0, 1'b0);  // R8
        run_op(8'h17, 8'h00, 1'b1, 1'b0);  // R8
        run_op(8'h1B, 8'h22, 1'b0, 1'b0);  // R8
        run_op(8'h1F, 8'h22, 1'b1, 1'b0);  // R8
        force_wait = 1;
        run_op(8'h75, 8'h00, 1'b1, 1'b1);  // R10 start while busy
        force_wait = -1;

        for (int n = 0; n < 400; n++) begin
            run_op(8'($urandom), 8'($urandom), 1'($urandom), 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule